// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector Bank

This block is the interrupt front end of one GPIO bank. The bank has several ports, and each port has several pins. Each pin watches its already-synchronized input for a trigger condition chosen by software. The choices are rising edge, falling edge, either edge, high level or low level. A detected condition sets a status bit for that pin. Each status bit is gated by a per-pin enable, and the gated bits of the whole bank are ORed into one registered interrupt line.

Software uses a simple write/read register port. Each port has four registers: the enable register, the 24-bit trigger-mode register, the read-only status register and the write-one-to-clear register.

An interrupt handler can clear an edge status before it services the event. A fresh edge that arrives after the clear, or in the same cycle as the clear, is never lost.

Top module: `gpio_irq_bank`

## Requirements
- R1: While reset is applied, every enable bit and every mode bit is forced to 0, and `irq_out` is 0. All-zero mode means low level, so pins held low show status 1 after reset, while `irq_out` stays 0.
- R2: The address is {select[1:0], port[1:0]}. Select 0 is enable (bits 7:0), 1 is mode, 2 is status (read only), 3 is clear. In a port's mode register, pin n uses bit n as polarity, bit n+8 as edge-select and bit n+16 as both-edges. Writing a register and reading it back returns the written value.
- R3: With mode (both,edge,pol) = (0,1,1), a 0-to-1 change of the pin sets its status bit.
- R4: With mode (0,1,0), a 1-to-0 change of the pin sets its status bit. A rising change does not set it.
- R5: With mode (1,1,0), a change of the pin in either direction sets its status bit.
- R6: With mode (0,0,1) the status bit equals the pin, and with (0,0,0) it equals the inverted pin, one cycle later. A clear write has no lasting effect while the level is still active.
- R7: Writing the clear register clears each edge status bit whose data bit is 1. Bits written as 0 leave their status unchanged.
- R8: If an edge on a pin and a clear of that pin land in the same cycle, the status stays set. An edge after a clear sets the status again.
- R9: `irq_out` is the registered OR over all pins of status AND enable. It changes exactly one cycle after status or enable changes.
- R10: `rd_data` shows the register selected by `rd_addr` one clock later. The clear register reads 0, and writes to the status register are ignored.
- R11: An edge is a difference between the current input and its value in the previous cycle. A single-cycle pulse is detected, and a pin held at a constant level produces no further events after a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 32 | Synchronized pin levels; pin p*8+n is port p, pin n |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address {select, port} |
| wr_data | input | 24 | Write data |
| rd_addr | input | 4 | Read address {select, port} |
| rd_data | output | 24 | Registered read data |
| irq_out | output | 1 | Registered bank interrupt |

## Verification
The assertions assume that `pin_in` is already synchronized to `clk` and carries known values whenever reset is low. Edge properties compare the input with its value one cycle earlier, so X or asynchronous changes on the pins would make them meaningless. The bench changes pins and register strobes only on falling clock edges and holds every pin at a known level from time zero. Between scenarios it returns unused pins to rising-edge mode with their inputs held low, so that only the pin under test can raise status.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_MODE   = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_CLEAR  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_irq_pin_cell.sv
// One pin: trigger decode and status flop.
module gpio_irq_pin_cell (
  input  logic clk,
  input  logic rst,
  input  logic pin_now,
  input  logic pin_prev,
  input  logic pol,
  input  logic edge_sel,
  input  logic both,
  input  logic clr,
  output logic status
);
  logic rise, fall, trig;

  always_comb begin
    rise = pin_now & ~pin_prev;
    fall = ~pin_now & pin_prev;
    if (both)
      trig = rise | fall;
    else if (pol)
      trig = rise;
    else
      trig = fall;
  end

  always_ff @(posedge clk) begin
    if (rst)
      status <= 1'b0;
    else if (!edge_sel)
      status <= (pin_now == pol);          // level: follow active level
    else
      status <= trig | (status & ~clr);    // edge: new event beats clear
  end
endmodule

// File: rtl/gpio_irq_port.sv
// One port: enable/mode registers, previous-sample register, pin cells.
module gpio_irq_port #(
  parameter int PINS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PINS-1:0]   pin_in,
  input  logic              en_we,
  input  logic              mode_we,
  input  logic              clr_we,
  input  logic [3*PINS-1:0] wdata,
  output logic [PINS-1:0]   en_q,
  output logic [3*PINS-1:0] mode_q,
  output logic [PINS-1:0]   status_q
);
  localparam int MODE_W = 3 * PINS;

  logic [PINS-1:0] pin_q;
  logic [PINS-1:0] clr_v;

  // The previous sample tracks the pin even in reset, so no edge appears at reset exit.
  always_ff @(posedge clk) pin_q <= pin_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      mode_q <= '0;
    end else begin
      if (en_we)   en_q   <= wdata[PINS-1:0];
      if (mode_we) mode_q <= wdata[MODE_W-1:0];
    end
  end

  assign clr_v = clr_we ? wdata[PINS-1:0] : '0;

  for (genvar n = 0; n < PINS; n++) begin : g_pin
    gpio_irq_pin_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .pin_now  (pin_in[n]),
      .pin_prev (pin_q[n]),
      .pol      (mode_q[n]),
      .edge_sel (mode_q[PINS + n]),
      .both     (mode_q[2*PINS + n]),
      .clr      (clr_v[n]),
      .status   (status_q[n])
    );
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int NUM_PORTS = 4,
  parameter int PINS      = 8,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int ADDR_W   = PORT_W + 2,
  localparam int MODE_W   = 3 * PINS,
  localparam int NPIN     = NUM_PORTS * PINS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPIN-1:0]   pin_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [MODE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [MODE_W-1:0] rd_data,
  output logic              irq_out
);
  import gpio_irq_pkg::*;

  reg_sel_e          wsel, rsel;
  logic [PORT_W-1:0] wport, rport;

  logic [NUM_PORTS-1:0][PINS-1:0]   en_arr, status_arr;
  logic [NUM_PORTS-1:0][MODE_W-1:0] mode_arr;
  logic [NPIN-1:0] status_all, en_all, pol_all, edge_all, both_all;

  assign wsel  = reg_sel_e'(wr_addr[ADDR_W-1 -: 2]);
  assign wport = wr_addr[PORT_W-1:0];
  assign rsel  = reg_sel_e'(rd_addr[ADDR_W-1 -: 2]);
  assign rport = rd_addr[PORT_W-1:0];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic hit;
    assign hit = wr_en && (int'(wport) == p);

    gpio_irq_port #(.PINS(PINS)) u_port (
      .clk      (clk),
      .rst      (rst),
      .pin_in   (pin_in[p*PINS +: PINS]),
      .en_we    (hit && (wsel == SEL_ENABLE)),
      .mode_we  (hit && (wsel == SEL_MODE)),
      .clr_we   (hit && (wsel == SEL_CLEAR)),
      .wdata    (wr_data),
      .en_q     (en_arr[p]),
      .mode_q   (mode_arr[p]),
      .status_q (status_arr[p])
    );

    assign pol_all [p*PINS +: PINS] = mode_arr[p][PINS-1:0];
    assign edge_all[p*PINS +: PINS] = mode_arr[p][2*PINS-1:PINS];
    assign both_all[p*PINS +: PINS] = mode_arr[p][3*PINS-1:2*PINS];
  end

  assign status_all = status_arr;
  assign en_all     = en_arr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (int'(rport) < NUM_PORTS) begin
      case (rsel)
        SEL_ENABLE: rd_data <= {{(MODE_W-PINS){1'b0}}, en_arr[rport]};
        SEL_MODE:   rd_data <= mode_arr[rport];
        SEL_STATUS: rd_data <= {{(MODE_W-PINS){1'b0}}, status_arr[rport]};
        default:    rd_data <= '0;
      endcase
    end else begin
      rd_data <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |(status_all & en_all);
  end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int NUM_PORTS = 4,
  parameter int PINS      = 8,
  localparam int NPIN     = NUM_PORTS * PINS
) (
  input logic            clk,
  input logic            rst,
  input logic [NPIN-1:0] pin_in,
  input logic            irq_out,
  input logic [NPIN-1:0] status_all,
  input logic [NPIN-1:0] en_all,
  input logic [NPIN-1:0] pol_all,
  input logic [NPIN-1:0] edge_all,
  input logic [NPIN-1:0] both_all
);
  logic past_valid;
  always_ff @(posedge clk) past_valid <= !rst;

  p_irq_reset_r1: assert property (@(posedge clk) rst |=> !irq_out);

  p_irq_follows_r9: assert property (@(posedge clk) disable iff (rst)
    past_valid |-> (irq_out == $past(|(status_all & en_all))));

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    p_rise_sets_r3: assert property (@(posedge clk) disable iff (rst)
      (past_valid && edge_all[i] && !both_all[i] && pol_all[i]
       && pin_in[i] && !$past(pin_in[i])) |=> status_all[i]);

    p_fall_sets_r4: assert property (@(posedge clk) disable iff (rst)
      (past_valid && edge_all[i] && !both_all[i] && !pol_all[i]
       && !pin_in[i] && $past(pin_in[i])) |=> status_all[i]);

    p_both_sets_r5: assert property (@(posedge clk) disable iff (rst)
      (past_valid && edge_all[i] && both_all[i]
       && (pin_in[i] != $past(pin_in[i]))) |=> status_all[i]);

    p_level_on_r6: assert property (@(posedge clk) disable iff (rst)
      (!edge_all[i] && (pin_in[i] == pol_all[i])) |=> status_all[i]);

    p_level_off_r6: assert property (@(posedge clk) disable iff (rst)
      (!edge_all[i] && (pin_in[i] != pol_all[i])) |=> !status_all[i]);
  end
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NUM_PORTS(NUM_PORTS), .PINS(PINS)) u_chk (.*);

// File: tb/tb_gpio_irq_bank.sv
module tb_gpio_irq_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pins = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [23:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [23:0] rd_data;
  logic        irq_out;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_irq_bank dut (
    .clk(clk), .rst(rst), .pin_in(pins), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_out(irq_out)
  );

  localparam logic [1:0] S_EN = 2'd0, S_MODE = 2'd1, S_STAT = 2'd2, S_CLR = 2'd3;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input int port, input logic [23:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = {sel, 2'(port)}; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, input int port, output logic [23:0] d);
    @(negedge clk);
    rd_addr = {sel, 2'(port)};
    @(negedge clk);
    d = rd_data;
  endtask

  // Mode codes m: 0 rise (0,1,1), 1 fall (0,1,0), 2 both (1,1,0), 3 high (0,0,1), 4 low (0,0,0)
  function automatic logic [23:0] mode_word(input int b, input int m);
    logic [23:0] w;
    logic bo, ed, po;
    w = 24'h00FFFF;
    bo = (m == 2); ed = (m <= 2); po = (m == 0) || (m == 3);
    w[b] = po; w[8+b] = ed; w[16+b] = bo;
    return w;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [23:0] d;
    logic        e;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 irq after reset", 32'(irq_out), 0);
    for (int p = 0; p < 4; p++) begin
      rd(S_EN, p, d);   chk("R1 enable reset", 32'(d), 0);
      rd(S_MODE, p, d); chk("R1 mode reset", 32'(d), 0);
      rd(S_STAT, p, d); chk("R1 low-level status after reset", 32'(d), 32'hFF);
    end
    chk("R1 irq stays low", 32'(irq_out), 0);

    for (int p = 0; p < 4; p++) begin
      wr(S_MODE, p, 24'h00FFFF);
      wr(S_CLR, p, 24'h0000FF);
      rd(S_MODE, p, d); chk("R2 mode readback", 32'(d), 32'h00FFFF);
      rd(S_STAT, p, d); chk("R7 clear all", 32'(d), 0);
    end

    // Sweep every pin through every mode
    for (int p = 0; p < 4; p++) begin
      for (int b = 0; b < 8; b++) begin
        for (int m = 0; m < 5; m++) begin
          wr(S_MODE, p, mode_word(b, m));
          wr(S_CLR, p, 24'hFF);
          wr(S_EN, p, 24'(1 << b));
          repeat (2) @(negedge clk);
          rd(S_STAT, p, d);
          e = (m == 4);
          chk("R6 idle-low status", 32'(d), 32'(e) << b);
          chk("R9 irq idle", 32'(irq_out), 32'(e));
          pins[p*8+b] = 1'b1;
          repeat (2) @(negedge clk);
          rd(S_STAT, p, d);
          e = (m == 0) || (m == 2) || (m == 3);
          chk("R3 R5 R6 after rise", 32'(d), 32'(e) << b);
          chk("R9 irq after rise", 32'(irq_out), 32'(e));
          wr(S_CLR, p, 24'(1 << b));
          repeat (2) @(negedge clk);
          rd(S_STAT, p, d);
          e = (m == 3);
          chk("R6 R11 after clear while high", 32'(d), 32'(e) << b);
          pins[p*8+b] = 1'b0;
          repeat (2) @(negedge clk);
          rd(S_STAT, p, d);
          e = (m == 1) || (m == 2) || (m == 4);
          chk("R4 R5 R8 after fall", 32'(d), 32'(e) << b);
          chk("R9 irq after fall", 32'(irq_out), 32'(e));
          wr(S_EN, p, 24'h0);
        end
        wr(S_MODE, p, 24'h00FFFF);
        wr(S_CLR, p, 24'hFF);
      end
    end

    // R9 cycle timing on port 0 pin 1
    wr(S_EN, 0, 24'h02);
    @(negedge clk);
    pins[1] = 1'b1;
    @(negedge clk);
    chk("R9 irq not yet", 32'(irq_out), 0);
    @(negedge clk);
    chk("R9 irq one cycle after status", 32'(irq_out), 1);
    wr(S_EN, 0, 24'h00);
    chk("R9 irq one cycle after enable drop", 32'(irq_out), 1);
    @(negedge clk);
    chk("R9 irq drops", 32'(irq_out), 0);

    // R10: a status write is ignored and the clear register reads 0
    wr(S_STAT, 0, 24'h000000);
    rd(S_STAT, 0, d); chk("R10 status write ignored", 32'(d), 32'h02);
    rd(S_CLR, 0, d);  chk("R10 clear reads zero", 32'(d), 0);
    wr(S_EN, 2, 24'hA5);
    rd(S_EN, 2, d);   chk("R2 enable readback", 32'(d), 32'hA5);
    wr(S_EN, 2, 24'h00);

    // R7: only the bits written as 1 are cleared
    pins[1] = 1'b0;
    wr(S_CLR, 0, 24'hFF);
    @(negedge clk);
    pins[0] = 1'b1; pins[1] = 1'b1;
    repeat (2) @(negedge clk);
    rd(S_STAT, 0, d); chk("R7 two set", 32'(d), 32'h03);
    wr(S_CLR, 0, 24'h01);
    rd(S_STAT, 0, d); chk("R7 zero bits untouched", 32'(d), 32'h02);

    // R8: an edge and a clear in the same cycle leave the status set
    pins[0] = 1'b0;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = {S_CLR, 2'd0}; wr_data = 24'h01;
    pins[0] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    rd(S_STAT, 0, d); chk("R8 edge beats clear", 32'(d & 24'h01), 1);

    // R11: a one-cycle pulse in both-edge mode on port 3 pin 7
    wr(S_MODE, 3, mode_word(7, 2));
    wr(S_CLR, 3, 24'hFF);
    @(negedge clk);
    pins[31] = 1'b1;
    @(negedge clk);
    pins[31] = 1'b0;
    wr(S_CLR, 3, 24'h7F);
    rd(S_STAT, 3, d); chk("R11 single-cycle pulse", 32'(d), 32'h80);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule